// File: doc/BRIEF.md
# Multiphase Clock Phase Rotator Bank

The block takes one clock delivered as a bundle of evenly spaced phases (eight of them by default, 45 degrees apart) and feeds several independent rotators (four by default). Each rotator holds a phase index. The index chooses which phase line drives that rotator's output clock. A single-cycle step request moves a rotator one position later, which is one eighth of the source period. When the index reaches the last position, the next step wraps it back to the first.

One active-low reset, sampled on the control clock, is shared by all rotators. It reloads each rotator with its own programmed starting index, not with zero. Control logic can therefore park every output at a known phase and then slide each output by fine steps. Changes on the starting-index inputs only take effect at the next reset.

Top module: `phase_rotator_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, each rotator's index (field k of `rot_idx`, bits [3k+2:3k]) loads the value on the matching field of `init_phase`.
- R2: With `rst_n` high, a high `step[k]` at a rising edge raises index k by one at that edge.
- R3: A step taken from index 7 wraps the index to 0.
- R4: A `step[k]` held high for N consecutive edges advances index k by N, modulo 8.
- R5: A low `rst_n` wins over any step request in the same cycle. The index loads `init_phase` and is not incremented.
- R6: A step on one rotator leaves the indices of all other rotators unchanged.
- R7: Output `rot_clk[k]` always equals `phases[i]`, where i is the current value of index k. This holds combinationally.
- R8: With `rst_n` high, a change on `init_phase` does not change any index.
- R9: With `rst_n` high and `step[k]` low, index k holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; steps and reset are sampled on its rising edge |
| rst_n | input | 1 | Shared synchronous active-low phase reset |
| phases | input | 8 | Evenly spaced phases of the source clock; bit i lags bit 0 by i eighths of a period |
| init_phase | input | 12 | Programmed starting index, 3 bits per rotator |
| step | input | 4 | Per-rotator request to move one phase later |
| rot_clk | output | 4 | Selected phase for each rotator |
| rot_idx | output | 12 | Current index, 3 bits per rotator |

## Verification
The bench uses the default build: eight phases and four rotators. With these values, every index wraps after only eight steps, so the random stream crosses the 7-to-0 boundary many times on every rotator. All four rotators run together in one bench, so cross-talk between rotators is checked in every cycle. The phase inputs are driven as static bit patterns, so the selection function can be compared bit by bit against the expected index without running fast clocks.

// File: rtl/pr_pkg.sv
// Package: shared helpers for the phase rotator bank.
// Assumes: indices are non-negative and smaller than the phase count.
package pr_pkg;

    // Next position on a ring of n phases, wrapping from n-1 to 0.
    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/pr_index_reg.sv
// Module: pr_index_reg
// Holds one rotator's phase index. Reset loads the programmed start.
// A step moves the index one position with wrap.
// Assumes: init_idx < NUM_PHASES; reset has priority over step.
module pr_index_reg #(
    parameter int NUM_PHASES = 8,
    localparam int IDX_W = $clog2(NUM_PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] init_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_nxt;

    // Compute the wrapped successor of the current index.
    always_comb begin
        idx_nxt = IDX_W'(pr_pkg::wrap_inc(int'(idx), NUM_PHASES));
    end

    // Reload on reset; otherwise advance on a step request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= init_idx;
        end else if (step) begin
            idx <= idx_nxt;
        end
    end
endmodule

// File: rtl/pr_phase_sel.sv
// Module: pr_phase_sel
// Picks one phase line by index. This is a plain combinational mux.
// Assumes: idx < NUM_PHASES. Glitch-free switching is out of scope.
module pr_phase_sel #(
    parameter int NUM_PHASES = 8,
    localparam int IDX_W = $clog2(NUM_PHASES)
) (
    input  logic [NUM_PHASES-1:0] phases,
    input  logic [IDX_W-1:0]      idx,
    output logic                  sel_clk
);
    // Route the addressed phase to the output.
    always_comb begin
        sel_clk = phases[idx];
    end
endmodule

// File: rtl/pr_rotator_slice.sv
// Module: pr_rotator_slice
// One rotator: an index register followed by the phase mux it drives.
// Assumes: shared reset and clock come from the bank.
module pr_rotator_slice #(
    parameter int NUM_PHASES = 8,
    localparam int IDX_W = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] phases,
    input  logic [IDX_W-1:0]      init_idx,
    input  logic                  step,
    output logic                  rot_clk,
    output logic [IDX_W-1:0]      idx
);
    pr_index_reg #(.NUM_PHASES(NUM_PHASES)) i_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_idx (init_idx),
        .step     (step),
        .idx      (idx)
    );

    pr_phase_sel #(.NUM_PHASES(NUM_PHASES)) i_sel (
        .phases  (phases),
        .idx     (idx),
        .sel_clk (rot_clk)
    );
endmodule

// File: rtl/phase_rotator_bank.sv
// Module: phase_rotator_bank
// A bank of NUM_ROT independent rotators sharing one phase bundle and one reset.
// Assumes: NUM_PHASES is a power of two, so every index value is a valid phase.
module phase_rotator_bank #(
    parameter int NUM_PHASES = 8,
    parameter int NUM_ROT    = 4,
    localparam int IDX_W = $clog2(NUM_PHASES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PHASES-1:0]    phases,
    input  logic [NUM_ROT*IDX_W-1:0] init_phase,
    input  logic [NUM_ROT-1:0]       step,
    output logic [NUM_ROT-1:0]       rot_clk,
    output logic [NUM_ROT*IDX_W-1:0] rot_idx
);
    // One slice per rotator, each on its own field of the packed buses.
    for (genvar k = 0; k < NUM_ROT; k++) begin : g_rot
        pr_rotator_slice #(.NUM_PHASES(NUM_PHASES)) i_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .phases   (phases),
            .init_idx (init_phase[k*IDX_W +: IDX_W]),
            .step     (step[k]),
            .rot_clk  (rot_clk[k]),
            .idx      (rot_idx[k*IDX_W +: IDX_W])
        );
    end
endmodule

// File: rtl/pr_bank_chk.sv
// Module: pr_bank_chk
// Checker for phase_rotator_bank. It watches only the top-level ports.
// Assumes: it is attached by the bind below.
module pr_bank_chk #(
    parameter int NUM_PHASES = 8,
    parameter int NUM_ROT    = 4,
    localparam int IDX_W = $clog2(NUM_PHASES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_PHASES-1:0]    phases,
    input logic [NUM_ROT*IDX_W-1:0] init_phase,
    input logic [NUM_ROT-1:0]       step,
    input logic [NUM_ROT-1:0]       rot_clk,
    input logic [NUM_ROT*IDX_W-1:0] rot_idx
);
    logic started;

    // Mark that at least one edge has passed, so $past has a history.
    always_ff @(posedge clk) begin
        started <= 1'b1;
    end

    for (genvar k = 0; k < NUM_ROT; k++) begin : g_chk
        // R1 R5
        reset_load_chk: assert property (@(posedge clk)
            (started && !rst_n) |=> (rot_idx[k*IDX_W +: IDX_W] == $past(init_phase[k*IDX_W +: IDX_W])));

        // R2 R3
        step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            step[k] |=> (rot_idx[k*IDX_W +: IDX_W] ==
                         IDX_W'(pr_pkg::wrap_inc(int'($past(rot_idx[k*IDX_W +: IDX_W])), NUM_PHASES))));

        // R9 R8 R6
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !step[k] |=> $stable(rot_idx[k*IDX_W +: IDX_W]));

        // R7
        sel_match_chk: assert property (@(negedge clk)
            started |-> (rot_clk[k] == phases[rot_idx[k*IDX_W +: IDX_W]]));
    end
endmodule

bind phase_rotator_bank pr_bank_chk #(.NUM_PHASES(NUM_PHASES), .NUM_ROT(NUM_ROT)) i_pr_bank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phases     (phases),
    .init_phase (init_phase),
    .step       (step),
    .rot_clk    (rot_clk),
    .rot_idx    (rot_idx)
);

// File: tb/test_phase_rotator_bank.sv
// Bench for phase_rotator_bank: directed corners, then seeded random stimulus.
module test_phase_rotator_bank;
    localparam int NP = 8;
    localparam int NR = 4;
    localparam int W  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] phases = '0;
    logic [NR*W-1:0] init_phase = '0;
    logic [NR-1:0] step = '0;
    logic [NR-1:0] rot_clk;
    logic [NR*W-1:0] rot_idx;

    int exp_idx [NR];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    phase_rotator_bank #(.NUM_PHASES(NP), .NUM_ROT(NR)) i_phase_rotator_bank (
        .clk(clk), .rst_n(rst_n), .phases(phases), .init_phase(init_phase),
        .step(step), .rot_clk(rot_clk), .rot_idx(rot_idx)
    );

    // 50 MHz control clock.
    always #10 clk = ~clk;

    function automatic int next_of(input int i);
        return (i + 1) % NP;
    endfunction

    function automatic int get_init(input int k);
        return int'(init_phase[k*W +: W]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, update the model at the edge, then settle away from the edge.
    task automatic tick(input logic r, input logic [NR-1:0] s);
        @(negedge clk);
        rst_n = r;
        step  = s;
        @(posedge clk);
        for (int k = 0; k < NR; k++) begin
            if (!r) exp_idx[k] = get_init(k);
            else if (s[k]) exp_idx[k] = next_of(exp_idx[k]);
        end
        #5;
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NR; k++)
            check(req, int'(rot_idx[k*W +: W]), exp_idx[k]);
    endtask

    task automatic check_sel(input string req);
        for (int k = 0; k < NR; k++)
            check(req, int'(rot_clk[k]), int'(phases[exp_idx[k]]));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset loads the per-rotator starting indices 3,0,7,5.
        init_phase = {3'd5, 3'd7, 3'd0, 3'd3};
        tick(1'b0, '0);
        tick(1'b0, '0);
        check_all("R1");

        // R8/R9: a new init value without reset and no steps leave the indices alone.
        init_phase = {3'd1, 3'd2, 3'd6, 3'd4};
        tick(1'b1, '0);
        tick(1'b1, '0);
        check_all("R8");
        check(  "R9", int'(rot_idx[0 +: W]), 3);

        // R3/R6: rotator 2 steps from 7 and wraps to 0; the others stay put.
        tick(1'b1, 4'b0100);
        check("R3", int'(rot_idx[2*W +: W]), 0);
        check("R6", int'(rot_idx[0 +: W]), 3);
        check("R6", int'(rot_idx[3*W +: W]), 5);

        // R2: a single step on rotator 1 moves it from 0 to 1.
        tick(1'b1, 4'b0010);
        check("R2", int'(rot_idx[1*W +: W]), 1);

        // R4: a step held for five cycles moves rotator 0 from 3 to 0.
        for (int n = 0; n < 5; n++) tick(1'b1, 4'b0001);
        check("R4", int'(rot_idx[0 +: W]), 0);

        // R5: reset with all steps high loads init without an increment.
        tick(1'b0, 4'b1111);
        check("R5", int'(rot_idx[0 +: W]), 4);
        check("R5", int'(rot_idx[1*W +: W]), 6);
        check("R5", int'(rot_idx[2*W +: W]), 2);
        check("R5", int'(rot_idx[3*W +: W]), 1);

        // R7: one-hot and inverted one-hot patterns on the phase lines.
        for (int p = 0; p < NP; p++) begin
            phases = NP'(1) << p;
            #1;
            check_sel("R7");
            phases = ~(NP'(1) << p);
            #1;
            check_sel("R7");
        end

        // Random mix; the model covers R1-style reloads and R2 steps each cycle.
        for (int c = 0; c < 2000; c++) begin
            logic r;
            r = ($urandom_range(0, 19) != 0);
            if ($urandom_range(0, 3) == 0) init_phase = NR*W'($urandom);
            phases = NP'($urandom);
            tick(r, NR'($urandom));
            check_all(r ? "R2" : "R1");
            check_sel("R7");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule